// File: doc/BRIEF.md
# Multi-Lane Ordered-Set Transmit Generator

This block produces the physical-layer ordered sets that a training state machine needs on the transmit side of a multi-lane serial link. The controller holds a level request for a TS1 or TS2 training set, a fast-training set or an electrical-idle set. The generator then emits that set on every lane, one 9-bit symbol per lane per cycle. Bit 8 of each symbol is the control flag and bits 7:0 are the byte. Training sets carry a link-number field and a lane-number field, and either field can be replaced by the PAD control symbol.

A free-running timer marks a skip ordered set as due once every `SKIP_INTERVAL` cycles. The due skip is sent at the next set boundary, but only once the data-link layer's packet-busy flag is low. A skip that stays blocked for several intervals is sent only once. The block also runs the receiver-detection exchange with the PIPE-style physical sub-layer: it raises the detect request with electrical idle, waits for the phy-status pulse, and reports a one-cycle done strobe together with the result.

Top module: `os_tx_gen`

## Requirements
- R1: While reset is held, every lane outputs D0.0 (9'h000), `os_valid_o` is 0, and `tx_det_lb_o`, `tx_elec_idle_o`, `det_done_o` and `det_result_o` are all 0.
- R2: A TS1 set lasts 16 cycles. Its symbols are COM (9'h1BC), the link field ({0,link_num_i}), the lane field ({0,lane index}), {0,N_FTS}, {0,RATE_ID}, {0,train_ctl_i}, and then ten copies of 9'h04A. The link and control fields are sampled in the cycle the set starts.
- R3: A TS2 set has the same layout as TS1, except that its ten identifier symbols are 9'h045.
- R4: When `pad_link_i` or `pad_lane_i` is high at the start of a training set, the corresponding field is PAD (9'h1F7) for that whole set.
- R5: Every lane carries the same symbol in every cycle, except for the lane-number field of a training set, where lane i carries i.
- R6: An FTS set is COM followed by three 9'h13C symbols. An idle set is COM followed by three 9'h17C symbols.
- R7: A skip becomes due on the SKIP_INTERVAL-th clock edge after reset and every SKIP_INTERVAL edges after that. A due skip starts at the first set boundary (any cycle with no set running, or the last symbol of a set) and takes priority over every request. It is COM followed by three 9'h11C symbols.
- R8: No set starts in a cycle where `pkt_busy_i` is high. A due skip waits for the flag to drop, and several intervals that expire while it waits produce only one skip.
- R9: When no set is running, every lane outputs D0.0 and `os_valid_o` is 0.
- R10: A detect request accepted while no set is running raises `tx_det_lb_o` and `tx_elec_idle_o` in the next cycle. Both stay high until `phy_status_i` is seen.
- R11: In the cycle after `phy_status_i`, `tx_det_lb_o` falls and `det_done_o` is high for exactly one cycle. `det_result_o` is 1 in that cycle only if `rx_status_i` was 3'b011 when phy-status arrived.
- R12: A detect request is held off while a set is running. No set, including a skip, starts during detection or during the cycle after `det_done_o`.
- R13: When several requests are present at a boundary, the order of preference is skip, then TS1, then TS2, then FTS, then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts1_req_i | input | 1 | Request TS1 sets |
| ts2_req_i | input | 1 | Request TS2 sets |
| fts_req_i | input | 1 | Request FTS sets |
| idl_req_i | input | 1 | Request idle sets |
| link_num_i | input | 8 | Link number for training sets |
| train_ctl_i | input | 8 | Training control byte |
| pad_link_i | input | 1 | Send PAD in the link field |
| pad_lane_i | input | 1 | Send PAD in the lane field |
| pkt_busy_i | input | 1 | Data-link packet in flight |
| det_req_i | input | 1 | Request receiver detection |
| phy_status_i | input | 1 | PIPE phy-status pulse |
| rx_status_i | input | 3 | PIPE receive status |
| sym_o | output | 9*NUM_LANES | Per-lane symbols, lane i at bits [9i+8:9i] |
| os_valid_o | output | 1 | An ordered set is being driven |
| tx_det_lb_o | output | 1 | PIPE detect/loopback request |
| tx_elec_idle_o | output | 1 | PIPE electrical idle |
| det_done_o | output | 1 | Detection finished (one cycle) |
| det_result_o | output | 1 | Receiver present, valid with done |

## Verification
Two functions can fall in the same cycle: the skip timer expiring and a set boundary claimed by another request, or by a packet or a detection that is blocking. The bench uses a 40-cycle interval and places held FTS and TS1 requests, a long packet-busy window spanning two expiries, and a detection exchange on the exact cycles where an expiry lands. It predicts from the cycle count alone where the skip COM must appear. It then checks that exactly one skip comes out and that the next boundary goes to the held request, not to a second skip.

// File: rtl/os_gen_pkg.sv
package os_gen_pkg;
  typedef enum logic [2:0] {
    SET_NONE, SET_SKP, SET_TS1, SET_TS2, SET_FTS, SET_IDL
  } set_kind_e;

  localparam logic [8:0] SYM_COM = 9'h1BC;
  localparam logic [8:0] SYM_SKP = 9'h11C;
  localparam logic [8:0] SYM_FTS = 9'h13C;
  localparam logic [8:0] SYM_IDL = 9'h17C;
  localparam logic [8:0] SYM_PAD = 9'h1F7;
  localparam logic [8:0] SYM_D00 = 9'h000;
  localparam logic [7:0] TS1_ID  = 8'h4A;
  localparam logic [7:0] TS2_ID  = 8'h45;
  localparam int unsigned POS_W  = 4;
endpackage

// File: rtl/skip_sched.sv
module skip_sched #(
  parameter int unsigned INTERVAL = 1180
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic pend_o
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          expire;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
      if (expire)      pend_q <= 1'b1;  // fresh expiry wins, never stacks
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q);
endmodule

// File: rtl/rx_detect_seq.sv
module rx_detect_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       phy_status_i,
  input  logic [2:0] rx_status_i,
  output logic       busy_o,
  output logic       det_lb_o,
  output logic       elec_idle_o,
  output logic       done_o,
  output logic       result_o
);
  typedef enum logic [1:0] {DS_IDLE, DS_WAIT, DS_DONE} det_st_e;

  localparam logic [2:0] RX_PRESENT = 3'b011;

  det_st_e st_q;
  logic    res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DS_IDLE;
      res_q <= 1'b0;
    end else begin
      unique case (st_q)
        DS_IDLE: if (start_i) st_q <= DS_WAIT;
        DS_WAIT: if (phy_status_i) begin
          st_q  <= DS_DONE;
          res_q <= (rx_status_i == RX_PRESENT);
        end
        DS_DONE: st_q <= DS_IDLE;
        default: st_q <= DS_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != DS_IDLE);
  assign det_lb_o    = (st_q == DS_WAIT);
  assign elec_idle_o = (st_q == DS_WAIT);
  assign done_o      = (st_q == DS_DONE);
  assign result_o    = done_o & res_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(phy_status_i));
  // R10
  lb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_lb_o |-> elec_idle_o);
endmodule

// File: rtl/os_lane_fmt.sv
module os_lane_fmt
  import os_gen_pkg::*;
#(
  parameter int unsigned LANE    = 0,
  parameter logic [7:0]  N_FTS   = 8'd24,
  parameter logic [7:0]  RATE_ID = 8'h02
) (
  input  set_kind_e        kind_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       link_i,
  input  logic             pad_link_i,
  input  logic             pad_lane_i,
  input  logic [7:0]       ctl_i,
  output logic [8:0]       sym_o
);
  localparam logic [7:0] LANE_NUM = 8'(LANE);

  logic [7:0] ts_id;
  assign ts_id = (kind_i == SET_TS2) ? TS2_ID : TS1_ID;

  always_comb begin
    sym_o = SYM_D00;
    unique case (kind_i)
      SET_NONE: sym_o = SYM_D00;
      SET_SKP:  sym_o = (pos_i == '0) ? SYM_COM : SYM_SKP;
      SET_FTS:  sym_o = (pos_i == '0) ? SYM_COM : SYM_FTS;
      SET_IDL:  sym_o = (pos_i == '0) ? SYM_COM : SYM_IDL;
      SET_TS1, SET_TS2: begin
        unique case (pos_i)
          4'd0:    sym_o = SYM_COM;
          4'd1:    sym_o = pad_link_i ? SYM_PAD : {1'b0, link_i};
          4'd2:    sym_o = pad_lane_i ? SYM_PAD : {1'b0, LANE_NUM};
          4'd3:    sym_o = {1'b0, N_FTS};
          4'd4:    sym_o = {1'b0, RATE_ID};
          4'd5:    sym_o = {1'b0, ctl_i};
          default: sym_o = {1'b0, ts_id};
        endcase
      end
      default: sym_o = SYM_D00;
    endcase
  end
endmodule

// File: rtl/os_tx_gen.sv
module os_tx_gen
  import os_gen_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 4,
  parameter int unsigned SKIP_INTERVAL = 1180,
  parameter logic [7:0]  N_FTS         = 8'd24,
  parameter logic [7:0]  RATE_ID       = 8'h02
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ts1_req_i,
  input  logic                   ts2_req_i,
  input  logic                   fts_req_i,
  input  logic                   idl_req_i,
  input  logic [7:0]             link_num_i,
  input  logic [7:0]             train_ctl_i,
  input  logic                   pad_link_i,
  input  logic                   pad_lane_i,
  input  logic                   pkt_busy_i,
  input  logic                   det_req_i,
  input  logic                   phy_status_i,
  input  logic [2:0]             rx_status_i,
  output logic [9*NUM_LANES-1:0] sym_o,
  output logic                   os_valid_o,
  output logic                   tx_det_lb_o,
  output logic                   tx_elec_idle_o,
  output logic                   det_done_o,
  output logic                   det_result_o
);
  localparam logic [POS_W-1:0] TS_LAST = POS_W'(15);
  localparam logic [POS_W-1:0] OS_LAST = POS_W'(3);

  set_kind_e        kind_q, kind_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [7:0]       link_q, ctl_q;
  logic             padl_q, padn_q;
  logic             is_ts, last, boundary, gate, det_take, det_busy;
  logic             skip_pend, take_skip;
  logic [8:0]       lane_sym [NUM_LANES];

  assign is_ts    = (kind_q == SET_TS1) || (kind_q == SET_TS2);
  assign last     = (pos_q == (is_ts ? TS_LAST : OS_LAST));
  assign boundary = (kind_q == SET_NONE) || last;
  assign det_take = det_req_i && !det_busy && (kind_q == SET_NONE);
  assign gate     = boundary && !pkt_busy_i && !det_busy && !det_take;
  assign take_skip = gate && skip_pend;

  always_comb begin
    kind_d = kind_q;
    pos_d  = pos_q + 1'b1;
    if (boundary) begin
      pos_d = '0;
      if (!gate)          kind_d = SET_NONE;
      else if (skip_pend) kind_d = SET_SKP;
      else if (ts1_req_i) kind_d = SET_TS1;
      else if (ts2_req_i) kind_d = SET_TS2;
      else if (fts_req_i) kind_d = SET_FTS;
      else if (idl_req_i) kind_d = SET_IDL;
      else                kind_d = SET_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= SET_NONE;
      pos_q  <= '0;
      link_q <= '0;
      ctl_q  <= '0;
      padl_q <= 1'b0;
      padn_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      pos_q  <= pos_d;
      if (boundary && gate) begin
        link_q <= link_num_i;
        ctl_q  <= train_ctl_i;
        padl_q <= pad_link_i;
        padn_q <= pad_lane_i;
      end
    end
  end

  skip_sched #(.INTERVAL(SKIP_INTERVAL)) u_skip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take_skip),
    .pend_o (skip_pend)
  );

  rx_detect_seq u_det (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (det_take),
    .phy_status_i (phy_status_i),
    .rx_status_i  (rx_status_i),
    .busy_o       (det_busy),
    .det_lb_o     (tx_det_lb_o),
    .elec_idle_o  (tx_elec_idle_o),
    .done_o       (det_done_o),
    .result_o     (det_result_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    os_lane_fmt #(.LANE(l), .N_FTS(N_FTS), .RATE_ID(RATE_ID)) u_fmt (
      .kind_i     (kind_q),
      .pos_i      (pos_q),
      .link_i     (link_q),
      .pad_link_i (padl_q),
      .pad_lane_i (padn_q),
      .ctl_i      (ctl_q),
      .sym_o      (lane_sym[l])
    );
    assign sym_o[9*l +: 9] = lane_sym[l];

    // R5
    lane_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(is_ts && pos_q == POS_W'(2)) |-> lane_sym[l] == lane_sym[0]);
  end

  assign os_valid_o = (kind_q != SET_NONE);

  // R8
  no_start_in_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_valid_o && pos_q == '0) |-> !$past(pkt_busy_i));
  // R12
  det_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_det_lb_o |-> !os_valid_o);
  // R12
  no_start_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_done_o |=> !os_valid_o);
endmodule

// File: tb/os_tx_gen_tb.sv
module os_tx_gen_tb;
  localparam int NL = 4;
  localparam int IV = 40;
  localparam logic [7:0] NF = 8'd24;
  localparam logic [7:0] RI = 8'h02;
  localparam logic [8:0] COM = 9'h1BC, SKP = 9'h11C, FTS = 9'h13C,
                         IDL = 9'h17C, PAD = 9'h1F7, D00 = 9'h000;

  logic clk = 0, rst_ni = 0;
  logic ts1 = 0, ts2 = 0, fts = 0, idl = 0, padl = 0, padn = 0;
  logic busy = 0, detq = 0, phys = 0;
  logic [7:0] link = 0, ctl = 0;
  logic [2:0] rxs = 0;
  logic [9*NL-1:0] sym;
  logic valid, dlb, eidle, done, res;
  int cyc = 0, checks = 0, fails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  os_tx_gen #(.NUM_LANES(NL), .SKIP_INTERVAL(IV), .N_FTS(NF), .RATE_ID(RI)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ts1_req_i(ts1), .ts2_req_i(ts2),
    .fts_req_i(fts), .idl_req_i(idl), .link_num_i(link), .train_ctl_i(ctl),
    .pad_link_i(padl), .pad_lane_i(padn), .pkt_busy_i(busy), .det_req_i(detq),
    .phy_status_i(phys), .rx_status_i(rxs), .sym_o(sym), .os_valid_o(valid),
    .tx_det_lb_o(dlb), .tx_elec_idle_o(eidle), .det_done_o(done),
    .det_result_o(res));

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic all_lanes(input logic [8:0] exp, input string tag);
    for (int l = 0; l < NL; l++) chk(sym[9*l +: 9], exp, tag);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // expects pos0 of a training set at the current negedge
  task automatic ts_seq(input bit two, input logic [7:0] lk, input bit pl,
                        input bit pn, input logic [7:0] c, input string tag);
    for (int p = 0; p < 16; p++) begin
      if (p == 2) begin
        for (int l = 0; l < NL; l++)
          chk(sym[9*l +: 9], pn ? PAD : {1'b0, 8'(l)}, "R5 lane field");
      end else begin
        logic [8:0] e;
        case (p)
          0: e = COM;
          1: e = pl ? PAD : {1'b0, lk};
          3: e = {1'b0, NF};
          4: e = {1'b0, RI};
          5: e = {1'b0, c};
          default: e = two ? 9'h045 : 9'h04A;
        endcase
        all_lanes(e, tag);
      end
      @(negedge clk);
    end
  endtask

  task automatic os4(input logic [8:0] body, input string tag);
    all_lanes(COM, tag);
    for (int p = 1; p < 4; p++) begin
      @(negedge clk);
      all_lanes(body, tag);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    all_lanes(D00, "R1 reset sym");
    chk({7'd0, valid}, 0, "R1 valid");
    chk({5'd0, dlb, eidle, done, res}, 0, "R1 det outs");
    @(negedge clk); rst_ni = 1;
    wait_to(10); all_lanes(D00, "R9 idle data"); chk({8'd0, valid}, 0, "R9 valid");
    wait_to(41); os4(SKP, "R7 first skip");
    wait_to(45); chk({8'd0, valid}, 0, "R9 after skip");
    wait_to(46); link = 8'h5A; ctl = 8'h0F; ts1 = 1;
    wait_to(47); ts1 = 0; ts_seq(0, 8'h5A, 0, 0, 8'h0F, "R2 ts1");
    chk({8'd0, valid}, 0, "R9 after ts1");
    wait_to(64); ts2 = 1; padl = 1; padn = 1; link = 8'h33; ctl = 8'h81;
    wait_to(65); ts2 = 0; padl = 0; padn = 0;
    ts_seq(1, 8'h33, 1, 1, 8'h81, "R3 R4 ts2 padded");
    chk(sym[8:0], COM, "R7 skip after set");
    wait_to(82); all_lanes(SKP, "R7 skip body");
    wait_to(116); fts = 1;
    wait_to(117); os4(FTS, "R6 fts");
    wait_to(121); os4(SKP, "R13 skip over held fts");
    wait_to(125); all_lanes(COM, "R6 fts resumes");
    wait_to(126); all_lanes(FTS, "R6 fts body"); fts = 0;
    wait_to(129); chk({8'd0, valid}, 0, "R9 after fts");
    wait_to(130); busy = 1; ts1 = 1; link = 8'h11; ctl = 8'h00;
    wait_to(150); chk({8'd0, valid}, 0, "R8 busy blocks");
    wait_to(170); chk({8'd0, valid}, 0, "R8 busy blocks skip");
    wait_to(201); chk({8'd0, valid}, 0, "R8 busy blocks 2nd");
    wait_to(205); busy = 0;
    wait_to(206); os4(SKP, "R8 deferred skip");
    wait_to(210); all_lanes(COM, "R8 single skip"); ts1 = 0;
    wait_to(211); all_lanes({1'b0, 8'h11}, "R8 ts1 after skip");
    wait_to(225); ts1 = 1; ts2 = 1; fts = 1; idl = 1;
    wait_to(232); all_lanes(9'h04A, "R13 ts1 first"); ts1 = 0;
    wait_to(242); os4(SKP, "R7 skip between");
    wait_to(252); all_lanes(9'h045, "R13 ts2 second"); ts2 = 0;
    wait_to(262); all_lanes(COM, "R13 fts third");
    wait_to(263); all_lanes(FTS, "R13 fts third"); fts = 0;
    wait_to(266); os4(IDL, "R6 idle set"); idl = 0;
    wait_to(270); chk({8'd0, valid}, 0, "R9 quiet");
    wait_to(290); detq = 1; ts1 = 1; link = 8'h07;
    wait_to(291);
    chk({7'd0, dlb, eidle}, 2'b11, "R10 det asserted"); chk({8'd0, valid}, 0, "R12 set held");
    detq = 0;
    wait_to(295); chk({7'd0, dlb, valid}, 2'b10, "R10 R12 wait");
    wait_to(300); phys = 1; rxs = 3'b011;
    wait_to(301); phys = 0; rxs = 0;
    chk({6'd0, dlb, done, res}, 3'b011, "R11 done present");
    wait_to(302); chk({6'd0, done, valid, dlb}, 0, "R11 R12 after done");
    wait_to(303); all_lanes(COM, "R12 ts1 after det"); ts1 = 0;
    wait_to(304); all_lanes({1'b0, 8'h07}, "R2 link after det");
    wait_to(321); os4(SKP, "R7 periodic");
    wait_to(330); detq = 1;
    wait_to(331); detq = 0; chk({8'd0, dlb}, 1, "R10 second det");
    wait_to(335); phys = 1; rxs = 3'b000;
    wait_to(336); phys = 0; chk({7'd0, done, res}, 2'b10, "R11 absent");
    wait_to(340); ts2 = 1;
    wait_to(341); ts2 = 0;
    wait_to(342); detq = 1;
    wait_to(345); chk({8'd0, dlb}, 0, "R12 det held off");
    wait_to(357); chk({8'd0, dlb}, 0, "R12 det at boundary");
    wait_to(358); chk({8'd0, dlb}, 1, "R12 det accepted"); detq = 0;
    wait_to(360); phys = 1; rxs = 3'b011;
    wait_to(361); phys = 0; rxs = 0; chk({7'd0, done, res}, 2'b11, "R11 third");
    wait_to(362); chk({8'd0, valid}, 0, "R12 skip held");
    wait_to(363); os4(SKP, "R7 R12 skip after det");
    finish_run();
  end
endmodule